// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets clocked logic read and write an external asynchronous static RAM of 8192 bytes. The host side issues one access at a time through a request/ready handshake. It supplies an address, a direction flag and, for writes, a data byte. Completion is marked by a single-cycle done pulse, and read data is returned on a held output. The memory side drives a pair of chip selects of opposite polarity, an active-low write strobe, an active-low output enable, the address, and a data bus split into output value, input value and output-drive enable.

The memory's timing limits are given in nanoseconds as parameters, together with the clock period. The controller turns each limit into a cycle count: the ceiling of the limit divided by the period, and never less than one cycle. A read holds select and output enable low for the whole access window and samples the bus in the last cycle of that window. A write first waits with the bus released, so that the memory's output drivers have time to float. It then drives the data and pulses the write strobe low, keeping output enable high throughout. Address and data stay unchanged for one cycle after the strobe rises.

Top module: `sram_async_ctl`

## Requirements
- R1: The two selects always have opposite levels. The memory is selected (`mem_ce_n`=0, `mem_ce`=1) only while an access is in progress.
- R2: During reset and whenever `host_ready` is 1, the controller is idle. In that state the pins are: `host_done`=0, `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R3: An accepted read holds select active, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0 on the latched address for RD cycles, where RD = max(ceil(70/T), ceil(40/T)) and T = 5 ns gives RD=14. `host_done` goes high RD clock edges after the accepting edge.
- R4: `host_rdata` returns the byte most recently written at that address, or 0 if the address was never written. The bus is sampled in the last cycle of the access window. `host_rdata` holds its value until the next read completes.
- R5: `mem_oe_n` stays high throughout every write, and `mem_we_n` and `mem_oe_n` are never low together.
- R6: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. In a write, `mem_dq_oe` rises only after TURN selected cycles with both strobes high. TURN = max(ceil(25/T), ceil(30/T)), which is 6.
- R7: The write strobe stays low for exactly WP cycles. WP = max(ceil(50/T), ceil(35/T), ceil(65/T)-TURN, ceil(70/T)-TURN-1), which is 10. Data is driven and address and data are stable throughout the pulse and for one cycle after `mem_we_n` rises, which meets the pulse, select-to-end, data setup and cycle minimums.
- R8: `host_done` is a single-cycle pulse. For a write it goes high TURN+WP clock edges (16) after the accepting edge.
- R9: A request made while `host_ready` is 0 is ignored. It changes neither the memory pins nor the stored contents.
- R10: Address and write data are captured on the accepting edge. Later changes on `host_addr` or `host_wdata` do not affect the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, accepted when `host_ready` is 1 |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 13 | Byte address |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | Controller idle and able to accept |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Last read byte, held |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | 13 | Memory address |
| mem_dq_o | output | 8 | Data driven toward memory |
| mem_dq_i | input | 8 | Data returned from memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |

## Verification
A wrong sequencer state shows up at the memory pins within one cycle. Typical symptoms are select held in idle, output enable low during a write, or the bus driven while output enable is low. Each of these trips a pin-level property on the next edge. A timing counter that is off by one either moves the done pulse by a cycle, which the handshake latency check reports, or samples or writes outside the memory model's allowed windows. The model answers an early sample with the inverted byte, so the corruption appears in `host_rdata` when that read completes.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RD_DONE,
        ST_WR_TURN,
        ST_WR_PULSE,
        ST_WR_END
    } seq_state_e;

    // Active-high view of the memory-side controls
    typedef struct packed {
        logic sel;
        logic we;
        logic oe;
        logic drive;
    } mem_ctl_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Ceiling of ns/period, never below one cycle
    function automatic int ns_to_cyc(input int ns, input int period);
        return imax(1, (ns + period - 1) / period);
    endfunction

    function automatic mem_ctl_t ctl_for(input seq_state_e s);
        mem_ctl_t c;
        c = '0;
        unique case (s)
            ST_RD:       begin c.sel = 1'b1; c.oe = 1'b1; end
            ST_WR_TURN:  c.sel = 1'b1;
            ST_WR_PULSE: begin c.sel = 1'b1; c.we = 1'b1; c.drive = 1'b1; end
            ST_WR_END:   begin c.sel = 1'b1; c.drive = 1'b1; end
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int RD_CYC   = 14,
    parameter int TURN_CYC = 6,
    parameter int WP_CYC   = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_write,
    input  logic             expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             capture,
    output mem_ctl_t         ctl,
    output logic             ready,
    output logic             done
);
    localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);

    seq_state_e state_q, state_d;
    mem_ctl_t   ctl_q;

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    tmr_load = 1'b1;
                    if (start_write) begin
                        state_d = ST_WR_TURN;
                        tmr_val = TURN_LD;
                    end else begin
                        state_d = ST_RD;
                        tmr_val = RD_LD;
                    end
                end
            end
            ST_RD: begin
                if (expired) begin
                    capture = 1'b1;
                    state_d = ST_RD_DONE;
                end
            end
            ST_RD_DONE: state_d = ST_IDLE;
            ST_WR_TURN: begin
                if (expired) begin
                    state_d  = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = WP_LD;
                end
            end
            ST_WR_PULSE: if (expired) state_d = ST_WR_END;
            ST_WR_END:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= '0;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_for(state_d);
        end
    end

    assign ctl   = ctl_q;
    assign ready = (state_q == ST_IDLE);
    assign done  = (state_q == ST_RD_DONE) || (state_q == ST_WR_END);
endmodule

// File: rtl/sram_io_regs.sv
module sram_io_regs #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] wdata_out,
    output logic [DATA_W-1:0] rdata_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_out  <= '0;
            wdata_out <= '0;
            rdata_out <= '0;
        end else begin
            if (accept) begin
                addr_out  <= in_addr;
                wdata_out <= in_wdata;
            end
            if (capture)
                rdata_out <= bus_in;
        end
    end
endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W          = 13,
    parameter int DATA_W          = 8,
    parameter int CLK_PERIOD_NS   = 5,
    parameter int T_CYCLE_NS      = 70,
    parameter int T_ADDR_ACC_NS   = 70,
    parameter int T_OE_ACC_NS     = 40,
    parameter int T_WE_PULSE_NS   = 50,
    parameter int T_CE_WRITE_NS   = 65,
    parameter int T_DATA_SETUP_NS = 35,
    parameter int T_OE_FLOAT_NS   = 25,
    parameter int T_WE_FLOAT_NS   = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_dq_oe
);
    localparam int CYC_CYCLE = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS);
    localparam int RD_CYC    = imax(imax(CYC_CYCLE, ns_to_cyc(T_ADDR_ACC_NS, CLK_PERIOD_NS)),
                                    ns_to_cyc(T_OE_ACC_NS, CLK_PERIOD_NS));
    localparam int TURN_CYC  = imax(ns_to_cyc(T_OE_FLOAT_NS, CLK_PERIOD_NS),
                                    ns_to_cyc(T_WE_FLOAT_NS, CLK_PERIOD_NS));
    localparam int WP_CYC    = imax(imax(ns_to_cyc(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                         ns_to_cyc(T_DATA_SETUP_NS, CLK_PERIOD_NS)),
                                    imax(ns_to_cyc(T_CE_WRITE_NS, CLK_PERIOD_NS) - TURN_CYC,
                                         CYC_CYCLE - TURN_CYC - 1));
    localparam int MAX_CYC   = imax(RD_CYC, imax(TURN_CYC, WP_CYC));
    localparam int CNT_W     = $clog2(MAX_CYC) + 1;

    logic             accept;
    logic             capture;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             expired;
    mem_ctl_t         ctl;

    assign accept = host_req && host_ready;

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    sram_seq_fsm #(
        .CNT_W    (CNT_W),
        .RD_CYC   (RD_CYC),
        .TURN_CYC (TURN_CYC),
        .WP_CYC   (WP_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .start_write (host_write),
        .expired     (expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .capture     (capture),
        .ctl         (ctl),
        .ready       (host_ready),
        .done        (host_done)
    );

    sram_io_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .in_addr   (host_addr),
        .in_wdata  (host_wdata),
        .bus_in    (mem_dq_i),
        .addr_out  (mem_addr),
        .wdata_out (mem_dq_o),
        .rdata_out (host_rdata)
    );

    assign mem_ce_n  = ~ctl.sel;
    assign mem_ce    = ctl.sel;
    assign mem_we_n  = ~ctl.we;
    assign mem_oe_n  = ~ctl.oe;
    assign mem_dq_oe = ctl.drive;
endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk #(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int TURN_CYC = 6,
    parameter int WP_CYC   = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              host_req,
    input logic              host_ready,
    input logic              host_done,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);
    logic [15:0] turn_cnt;
    logic [15:0] low_cnt;
    logic        sel;

    assign sel = !mem_ce_n && mem_ce;

    // selected cycles with both strobes high and the bus released
    always_ff @(posedge clk) begin
        if (rst || !sel)
            turn_cnt <= '0;
        else if (mem_oe_n && mem_we_n && !mem_dq_oe && turn_cnt != 16'hFFFF)
            turn_cnt <= turn_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || mem_we_n)
            low_cnt <= '0;
        else if (low_cnt != 16'hFFFF)
            low_cnt <= low_cnt + 1'b1;
    end

    p_sel_pair_r1: assert property (@(posedge clk) disable iff (rst)
        mem_ce_n != mem_ce);

    p_idle_pins_r2: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !host_done));

    p_we_oe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    p_no_drive_oe_r6: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    p_turn_wait_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (turn_cnt >= 16'(TURN_CYC)));

    p_wp_len_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (low_cnt == 16'(WP_CYC)));

    p_we_rise_hold_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (mem_dq_oe && sel && $stable(mem_addr) && $stable(mem_dq_o)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        host_done |=> !host_done);

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(host_req && host_ready) |=> $stable(mem_addr));
endmodule

bind sram_async_ctl sram_async_ctl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TURN_CYC (TURN_CYC),
    .WP_CYC   (WP_CYC)
) u_chk (.*);

// File: tb/sram_async_ctl_bench.sv
`timescale 1ns/1ps
module sram_async_ctl_bench;
    localparam int AW = 13;
    localparam int DW = 8;
    localparam int TP = 5;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + TP - 1) / TP;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int EXP_RD   = mx(cyc(70), cyc(40));
    localparam int EXP_TURN = mx(cyc(25), cyc(30));
    localparam int EXP_WP   = mx(mx(cyc(50), cyc(35)), mx(cyc(65) - EXP_TURN, cyc(70) - EXP_TURN - 1));

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_req = 1'b0;
    logic          host_write = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_ready, host_done;
    logic [DW-1:0] host_rdata;
    logic          mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_o;
    logic [DW-1:0] mdl_dq = '0;

    int tests = 0;
    int fails = 0;
    int viol  = 0;
    bit [31:0] seed = 32'h1234_5678;
    logic [DW-1:0] shadow [int unsigned];

    always #2.5 clk = ~clk;

    sram_async_ctl u_sram_async_ctl (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_done(host_done), .host_rdata(host_rdata),
        .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_i(mdl_dq), .mem_dq_oe(mem_dq_oe)
    );

    // ---------------- behavioural memory model ----------------
    logic [DW-1:0] mem [int unsigned];
    realtime t_sel = 0, t_addr = 0, t_oe = 0, t_we = 0, t_dat = 0, t_rel = -100;
    bit p_sel = 0, p_oe = 0, p_we = 0, p_drv = 0, p_dqoe = 0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dqo = '0;

    function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : '0;
    endfunction

    task automatic model_step();
        bit sel, oe, we, drv, ok;
        realtime now, est, acc;
        now = $realtime;
        est = now - 1.0;
        sel = !mem_ce_n && mem_ce;
        oe  = !mem_oe_n;
        we  = !mem_we_n;
        if (sel && !p_sel) t_sel = est;
        if (mem_addr != p_addr) t_addr = est;
        if (oe && !p_oe) t_oe = est;
        if (we && !p_we) t_we = est;
        if ((mem_dq_o != p_dqo) || (mem_dq_oe && !p_dqoe)) t_dat = est;
        drv = sel && oe && !we;
        if (p_drv && !drv) t_rel = est;
        // end of write
        if (p_we && p_sel && !(we && sel)) begin
            if (est - t_we < 50.0) begin viol++; $display("[MDL] write pulse too short"); end
            if (est - t_sel < 65.0) begin viol++; $display("[MDL] select-to-end too short"); end
            if (est - t_dat < 35.0) begin viol++; $display("[MDL] data setup too short"); end
            if (!p_dqoe) begin viol++; $display("[MDL] write without driven data"); end
            mem[int'(p_addr)] = p_dqo;
        end
        if (mem_dq_oe && (drv || (now - t_rel < 25.0))) begin
            viol++; $display("[MDL] bus contention at %0t", $time);
        end
        if (drv) begin
            acc = (t_sel > t_addr) ? t_sel : t_addr;
            ok = (now - acc >= 70.0) && (now - t_oe >= 40.0);
            mdl_dq = ok ? mem_rd(mem_addr) : ~mem_rd(mem_addr);
        end else begin
            mdl_dq = '0;
        end
        p_sel = sel; p_oe = oe; p_we = we; p_drv = drv;
        p_addr = mem_addr; p_dqo = mem_dq_o; p_dqoe = mem_dq_oe;
    endtask

    initial begin
        #0.5;
        forever begin
            model_step();
            #1;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
        return shadow.exists(int'(a)) ? shadow[int'(a)] : '0;
    endfunction

    // write; scramble changes host inputs right after acceptance (R10)
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit scramble);
        int n, we_low, first_drv, oe_low;
        @(negedge clk);
        chk(host_ready, "R2 ready before write", host_ready, 1);
        host_req = 1; host_write = 1; host_addr = a; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_req = 0;
        if (scramble) begin host_addr = ~a; host_wdata = ~d; end
        n = 0; we_low = 0; first_drv = -1; oe_low = 0;
        while (!host_done && n < 100) begin
            if (!mem_we_n) we_low++;
            if (mem_dq_oe && first_drv < 0) first_drv = n;
            if (!mem_oe_n) oe_low++;
            @(posedge clk); n++;
            @(negedge clk);
        end
        chk(n == EXP_TURN + EXP_WP, "R8 write done latency", n, EXP_TURN + EXP_WP);
        chk(we_low == EXP_WP, "R7 write strobe width", we_low, EXP_WP);
        chk(first_drv == EXP_TURN, "R6 bus turnaround wait", first_drv, EXP_TURN);
        chk(oe_low == 0, "R5 output enable low in write", oe_low, 0);
        chk(mem_dq_oe && mem_we_n && mem_addr == a, "R7 hold after strobe", mem_addr, a);
        shadow[int'(a)] = d;
        @(negedge clk);
        chk(!host_done, "R8 done single pulse", host_done, 0);
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        int n, bad;
        @(negedge clk);
        chk(host_ready, "R2 ready before read", host_ready, 1);
        host_req = 1; host_write = 0; host_addr = a;
        @(posedge clk);
        @(negedge clk);
        host_req = 0;
        n = 0; bad = 0;
        while (!host_done && n < 100) begin
            if (mem_oe_n || !mem_we_n || mem_dq_oe || mem_ce_n || !mem_ce || mem_addr != a) bad++;
            @(posedge clk); n++;
            @(negedge clk);
        end
        chk(n == EXP_RD, "R3 read done latency", n, EXP_RD);
        chk(bad == 0, "R3 R1 pins during read window", bad, 0);
        d = host_rdata;
        chk(host_rdata == exp_rd(a), "R4 read data", host_rdata, exp_rd(a));
        @(negedge clk);
        chk(!host_done, "R8 done single pulse", host_done, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(host_ready && !host_done, "R2 reset handshake", {host_ready, host_done}, 2'b10);
        chk(mem_ce_n && !mem_ce, "R1 deselected after reset", {mem_ce_n, mem_ce}, 2'b10);
        chk(mem_we_n && mem_oe_n && !mem_dq_oe, "R2 strobes after reset",
            {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b110);
    endtask

    task automatic t_basic();
        logic [DW-1:0] d;
        do_write(13'h0000, 8'h5A, 0);
        do_write(13'h1FFF, 8'hC3, 0);
        do_read(13'h0000, d);
        do_read(13'h1FFF, d);
        do_read(13'h0ABC, d);   // never written: R4 expects 0
        @(negedge clk);
        chk(mem_ce_n && !mem_ce && host_ready, "R1 deselect when idle", {mem_ce_n, mem_ce}, 2'b10);
    endtask

    task automatic t_random();
        logic [AW-1:0] al [24];
        logic [DW-1:0] d;
        foreach (al[i]) begin
            al[i] = AW'(rnd());
            do_write(al[i], DW'(rnd()), 0);
        end
        foreach (al[i]) do_read(al[i], d);
    endtask

    task automatic t_busy_ignored();
        int bad;
        do_write(13'd100, 8'h11, 0);
        do_write(13'd200, 8'h22, 0);
        @(negedge clk);
        host_req = 1; host_write = 0; host_addr = 13'd100;
        @(posedge clk);
        @(negedge clk);
        host_write = 1; host_addr = 13'd200; host_wdata = 8'hEE;  // req stays high while busy
        bad = 0;
        for (int k = 0; k < 5; k++) begin
            if (mem_addr != 13'd100 || !mem_we_n || host_ready) bad++;
            @(negedge clk);
        end
        host_req = 0;
        chk(bad == 0, "R9 request while busy ignored", bad, 0);
        while (!host_done) @(negedge clk);
        chk(host_rdata == 8'h11, "R9 busy read data", host_rdata, 8'h11);
        begin
            logic [DW-1:0] d;
            do_read(13'd200, d);
            chk(d == 8'h22, "R9 no stray write", d, 8'h22);
        end
    endtask

    task automatic t_latched_inputs();
        logic [DW-1:0] d;
        do_write(13'h0F0F, 8'h00, 0);   // the complement address holds known data
        do_write(13'h10F0, 8'h77, 1);   // host inputs flip to 0x0F0F/0x88 after accept
        do_read(13'h10F0, d);
        chk(d == 8'h77, "R10 write data latched", d, 8'h77);
        do_read(13'h0F0F, d);
        chk(d == 8'h00, "R10 address latched", d, 8'h00);
    endtask

    task automatic t_rdata_hold();
        logic [DW-1:0] d;
        do_write(13'h0042, 8'hB6, 0);
        do_read(13'h0042, d);
        do_write(13'h0043, 8'h19, 0);
        @(negedge clk);
        chk(host_rdata == 8'hB6, "R4 read data held across write", host_rdata, 8'hB6);
    endtask

    task automatic t_model_clean();
        repeat (4) @(negedge clk);
        chk(viol == 0, "R6 R7 memory timing windows respected", viol, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 0;
        t_reset();
        t_basic();
        t_random();
        t_busy_ignored();
        t_latched_inputs();
        t_rdata_hold();
        t_model_clean();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule